// File: doc/BRIEF.md
# ATAPI Packet Command Decoder with Sense Store

This block sits behind a task-file controller and turns a 12-byte command packet into a transfer setup. It reports the byte count to move, the direction, whether DMA is used, and for sector reads the start block, block count and sector mode. It then updates the task-file status, error and count values and raises an interrupt pulse where the protocol calls for one. Every packet produces a 16-bit result code. The low byte of that code is the sense key and the high byte is the additional sense code. The block copies the code into a 10-byte sense store that the host can read back.

For data-in commands whose content the block owns, the response bytes are streamed into a shared buffer, one byte per cycle, starting at buffer address 0. These are sense readback, mode-parameter readback and the position-status header. The bytes are captured when the packet is decoded, so a sense readback returns the sense contents as they stood before this packet updated them. A 10-byte mode-parameter area is loaded with a default image at reset. It is rewritten by the data phase that follows a mode-select packet. After reset, a unit-attention rule applies: the first packet that is not a sense request is answered with an attention result and is not executed.

Media reads and table-of-contents contents are handled elsewhere. The session-info command only clamps its length and streams zero bytes.

Top module: `atapi_pkt_core`

## Requirements
- R1: After reset the task-file values are status 0x00, error 0x01 and count 0x01. The sense store is all zero. Mode byte i holds 0xA0+i. Attention is armed. No result and no buffer write is issued.
- R2: Every packet sets sense byte 0 to 0xF0, sense byte 2 to result[7:0] and sense byte 8 to result[15:8].
- R3: A nonzero result sets status 0x51, error = result[3:0]<<4 and count 3, gives xfer_len 0, and pulses irq_pulse in the res_valid cycle.
- R4: Read-sector (opcode 0x30) outputs a start block of {b2,b3,b4}, a block count of {b8,b9,b10} and a sector mode of b1, where bN is packet byte N. It gives result 0 and xfer_len 0, clears bits 7 and 0 of the previous status, sets count 3 and raises no interrupt.
- R5: While attention is armed, a packet whose opcode is not 0x13 returns result 0x2906 without executing, and attention is disarmed. An opcode 0x13 packet executes normally and leaves attention armed.
- R6: Sense request (0x13) returns min(b4,10) bytes, and those bytes reflect the sense store as it was before this packet.
- R7: Mode sense (0x11) and mode select (0x12) take their offset from b2 and their length from b4. An offset of 10 or more gives result 0x2405. Otherwise the length is min(b4, 10 - offset), and mode sense returns the area bytes starting at that offset.
- R8: Session info (0x15) is clamped to 6 bytes. The status command (0x40) with b1=1 is clamped to 14 bytes and starts with the header 00 15 00 0E. Any other b1 value gives 0x2405.
- R9: Opcodes 0x00, 0x15, 0x30 and 0x40 return 0x3A02 when no disc is present. An undefined opcode returns 0x2005. Test-ready (0x00) with a disc present gives result 0, status 0x50, count 3 and an interrupt.
- R10: After a mode select, the following wr_valid bytes are written into the area starting at the stored offset, up to the clamped length. Bytes beyond that length are ignored.
- R11: A data-in setup gives count 2 and a data-out setup gives count 0. With feat_dma=0 the status is 0x58 and an interrupt is raised. With feat_dma=1 the status is 0xD0 and no interrupt is raised.
- R12: A data-in result writes xfer_len bytes to addresses 0, 1, 2 and so on, on consecutive cycles. The first write occurs in the same cycle as res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_data | input | 96 | Packet, byte N at bits 8N+7:8N |
| feat_dma | input | 1 | Feature-register DMA select |
| disc_present | input | 1 | Medium loaded |
| wr_valid | input | 1 | Host data byte for mode select |
| wr_data | input | 8 | Host data byte |
| res_valid | output | 1 | Result available (one cycle) |
| res_code | output | 16 | Result: key low byte, additional code high byte |
| xfer_len | output | 16 | Byte count of the data phase |
| xfer_dir | output | 1 | 1 = device to host |
| xfer_dma | output | 1 | Data phase uses DMA |
| xfer_sectors | output | 24 | Read-sector block count |
| xfer_lba | output | 24 | Read-sector start block |
| xfer_mode | output | 8 | Read-sector mode byte |
| tf_status | output | 8 | Task-file status value |
| tf_error | output | 8 | Task-file error value |
| tf_count | output | 8 | Task-file interrupt-reason count |
| irq_pulse | output | 1 | Interrupt request pulse |
| buf_we | output | 1 | Shared buffer write strobe |
| buf_addr | output | 8 | Shared buffer byte address |
| buf_data | output | 8 | Shared buffer byte |

## Verification
The vector table covers a range of requested lengths: below the cap, equal to it and far above it. Each case shows whether the clamp uses the command's own maximum rather than a shared one. Offsets at the area's edge, just inside it and at zero separate the bad-field path from the offset-reduced length. Disc-absent cases against unknown opcodes show that the media check comes before dispatch, and DMA against PIO separates the two setup encodings. Streamed readback after an error, twice in a row, shows that sense is captured before the result overwrites it. The reset sequence shows the attention rule exempting sense requests.

// File: rtl/atapi_pkt_pkg.sv
package atapi_pkt_pkg;

   localparam logic [7:0] OP_TEST   = 8'h00;
   localparam logic [7:0] OP_MSENSE = 8'h11;
   localparam logic [7:0] OP_MSEL   = 8'h12;
   localparam logic [7:0] OP_RSENSE = 8'h13;
   localparam logic [7:0] OP_SESS   = 8'h15;
   localparam logic [7:0] OP_RDSEC  = 8'h30;
   localparam logic [7:0] OP_STAT   = 8'h40;

   localparam logic [15:0] RC_OK     = 16'h0000;
   localparam logic [15:0] RC_ATTN   = 16'h2906;
   localparam logic [15:0] RC_NODISC = 16'h3A02;
   localparam logic [15:0] RC_BADOP  = 16'h2005;
   localparam logic [15:0] RC_BADFLD = 16'h2405;

   localparam logic [7:0] ST_ERR   = 8'h51;
   localparam logic [7:0] ST_RDY   = 8'h50;
   localparam logic [7:0] ST_PIO   = 8'h58;
   localparam logic [7:0] ST_DMA   = 8'hD0;
   localparam logic [7:0] ST_KEEP  = 8'h7E;

   typedef enum logic [2:0] {K_ERR, K_DIN, K_DOUT, K_DONE, K_SEEK} kind_e;

   typedef struct packed {
      logic [15:0] code;
      kind_e       kind;
      logic [15:0] len;
      logic [23:0] lba;
      logic [23:0] sectors;
      logic [7:0]  smode;
      logic [7:0]  moff;
   } dec_s;

   function automatic logic [15:0] clamp8(logic [7:0] req, logic [15:0] lim);
      return ({8'h00, req} > lim) ? lim : {8'h00, req};
   endfunction

endpackage

// File: rtl/atapi_pkt_decode.sv
module atapi_pkt_decode
   import atapi_pkt_pkg::*;
#(
   parameter int SENSE_LEN = 10,
   parameter int MODE_LEN  = 10,
   parameter int SESS_MAX  = 6,
   parameter int STAT_MAX  = 14,
   parameter int RESP_MAX  = 14
) (
   input  logic [11:0][7:0]          pkt,
   input  logic                      attn,
   input  logic                      disc,
   input  logic [SENSE_LEN-1:0][7:0] sense,
   input  logic [MODE_LEN-1:0][7:0]  mode,
   output dec_s                      dec,
   output logic [RESP_MAX-1:0][7:0]  img
);

   typedef enum logic [1:0] {SRC_NONE, SRC_SENSE, SRC_MODE, SRC_STAT} src_e;

   localparam logic [3:0][7:0] STAT_HDR = {8'h0E, 8'h00, 8'h15, 8'h00};

   src_e       src;
   logic [7:0] op;
   logic       off_bad;

   assign op      = pkt[0];
   assign off_bad = ({8'h00, pkt[2]} >= 16'(MODE_LEN));

   if (RESP_MAX < STAT_MAX || RESP_MAX < SENSE_LEN || RESP_MAX < MODE_LEN || RESP_MAX < SESS_MAX)
   begin : g_bad_resp
      $error("RESP_MAX must cover every response length");
   end

   always_comb begin
      dec      = '0;
      dec.kind = K_ERR;
      dec.code = RC_OK;
      src      = SRC_NONE;
      if (attn && op != OP_RSENSE) begin
         dec.code = RC_ATTN;
      end else begin
         unique case (op)
            OP_TEST: begin
               if (!disc) dec.code = RC_NODISC;
               else       dec.kind = K_DONE;
            end
            OP_MSENSE: begin
               if (off_bad) dec.code = RC_BADFLD;
               else begin
                  dec.kind = K_DIN;
                  dec.len  = clamp8(pkt[4], 16'(MODE_LEN) - {8'h00, pkt[2]});
                  src      = SRC_MODE;
               end
            end
            OP_MSEL: begin
               if (off_bad) dec.code = RC_BADFLD;
               else begin
                  dec.kind = K_DOUT;
                  dec.len  = clamp8(pkt[4], 16'(MODE_LEN) - {8'h00, pkt[2]});
                  dec.moff = pkt[2];
               end
            end
            OP_RSENSE: begin
               dec.kind = K_DIN;
               dec.len  = clamp8(pkt[4], 16'(SENSE_LEN));
               src      = SRC_SENSE;
            end
            OP_SESS: begin
               if (!disc) dec.code = RC_NODISC;
               else begin
                  dec.kind = K_DIN;
                  dec.len  = clamp8(pkt[4], 16'(SESS_MAX));
               end
            end
            OP_RDSEC: begin
               if (!disc) dec.code = RC_NODISC;
               else begin
                  dec.kind    = K_SEEK;
                  dec.lba     = {pkt[2], pkt[3], pkt[4]};
                  dec.sectors = {pkt[8], pkt[9], pkt[10]};
                  dec.smode   = pkt[1];
               end
            end
            OP_STAT: begin
               if (!disc)                dec.code = RC_NODISC;
               else if (pkt[1] != 8'h01) dec.code = RC_BADFLD;
               else begin
                  dec.kind = K_DIN;
                  dec.len  = clamp8(pkt[4], 16'(STAT_MAX));
                  src      = SRC_STAT;
               end
            end
            default: dec.code = RC_BADOP;
         endcase
      end
   end

   for (genvar j = 0; j < RESP_MAX; j++) begin : g_lane
      logic [7:0] v_sense, v_mode, v_stat;

      if (j < SENSE_LEN) begin : g_s
         assign v_sense = sense[j];
      end else begin : g_sz
         assign v_sense = 8'h00;
      end

      if (j < 4) begin : g_h
         assign v_stat = STAT_HDR[j];
      end else begin : g_hz
         assign v_stat = 8'h00;
      end

      always_comb begin
         v_mode = 8'h00;
         for (int k = 0; k < MODE_LEN; k++)
            if ({1'b0, pkt[2]} + 9'(j) == 9'(k)) v_mode = mode[k];
      end

      always_comb begin
         unique case (src)
            SRC_SENSE: img[j] = v_sense;
            SRC_MODE:  img[j] = v_mode;
            SRC_STAT:  img[j] = v_stat;
            default:   img[j] = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/atapi_sense_store.sv
module atapi_sense_store
   import atapi_pkt_pkg::*;
#(
   parameter int                      SENSE_LEN = 10,
   parameter int                      MODE_LEN  = 10,
   parameter logic [MODE_LEN*8-1:0]   MODE_INIT = 80'hA9A8A7A6A5A4A3A2A1A0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd,
   input  logic [15:0]               code,
   input  logic                      arm,
   input  logic [7:0]                arm_off,
   input  logic [15:0]               arm_len,
   input  logic                      wr_valid,
   input  logic [7:0]                wr_data,
   output logic [SENSE_LEN-1:0][7:0] sense,
   output logic [MODE_LEN-1:0][7:0]  mode
);

   localparam int KEY_IX = 2;
   localparam int ASC_IX = 8;

   if (SENSE_LEN <= ASC_IX) begin : g_bad_sense
      $error("SENSE_LEN too small for the sense layout");
   end

   logic [7:0]  wr_ptr;
   logic [15:0] wr_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sense   <= '0;
         mode    <= MODE_INIT;
         wr_ptr  <= '0;
         wr_left <= '0;
      end else begin
         if (upd) begin
            sense[0]      <= 8'hF0;
            sense[KEY_IX] <= code[7:0];
            sense[ASC_IX] <= code[15:8];
         end
         if (arm) begin
            wr_ptr  <= arm_off;
            wr_left <= arm_len;
         end else if (wr_valid && wr_left != 16'd0) begin
            for (int k = 0; k < MODE_LEN; k++)
               if (wr_ptr == 8'(k)) mode[k] <= wr_data;
            wr_ptr  <= wr_ptr + 8'd1;
            wr_left <= wr_left - 16'd1;
         end
      end
   end

   // R10: the open write window never reaches past the area
   a_r10_wr_window: assert property (@(posedge clk) disable iff (!rst_n)
      wr_left != 16'd0 |-> ({8'h00, wr_ptr} + wr_left) <= 16'(MODE_LEN));

   // R2: sense header follows each result
   a_r2_sense_tag: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> sense[0] == 8'hF0 && sense[KEY_IX] == $past(code[7:0])
              && sense[ASC_IX] == $past(code[15:8]));

endmodule

// File: rtl/atapi_resp_stream.sv
module atapi_resp_stream #(
   parameter int RESP_MAX = 14,
   parameter int ADDR_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [15:0]              len,
   input  logic [RESP_MAX-1:0][7:0] img,
   output logic                     we,
   output logic [ADDR_W-1:0]        addr,
   output logic [7:0]               data
);

   if (RESP_MAX >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for RESP_MAX");
   end

   logic [15:0]              cnt;
   logic [ADDR_W-1:0]        idx;
   logic [RESP_MAX-1:0][7:0] img_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         idx   <= '0;
         img_q <= '0;
      end else if (load) begin
         cnt   <= len;
         idx   <= '0;
         img_q <= img;
      end else if (cnt != 16'd0) begin
         cnt <= cnt - 16'd1;
         idx <= idx + 1'b1;
      end
   end

   assign we   = (cnt != 16'd0);
   assign addr = idx;

   always_comb begin
      data = 8'h00;
      for (int k = 0; k < RESP_MAX; k++)
         if (idx == ADDR_W'(k)) data = img_q[k];
   end

   // R12: consecutive addresses within one burst
   a_r12_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      we && !load |=> !we || addr == $past(addr) + 1'b1);

   // R12: writes stay inside the response image
   a_r12_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> addr < ADDR_W'(RESP_MAX));

endmodule

// File: rtl/atapi_pkt_core.sv
module atapi_pkt_core
   import atapi_pkt_pkg::*;
#(
   parameter int                    SENSE_LEN = 10,
   parameter int                    MODE_LEN  = 10,
   parameter int                    SESS_MAX  = 6,
   parameter int                    STAT_MAX  = 14,
   parameter int                    ADDR_W    = 8,
   parameter logic [MODE_LEN*8-1:0] MODE_INIT = 80'hA9A8A7A6A5A4A3A2A1A0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pkt_valid,
   input  logic [95:0] pkt_data,
   input  logic        feat_dma,
   input  logic        disc_present,
   input  logic        wr_valid,
   input  logic [7:0]  wr_data,
   output logic        res_valid,
   output logic [15:0] res_code,
   output logic [15:0] xfer_len,
   output logic        xfer_dir,
   output logic        xfer_dma,
   output logic [23:0] xfer_sectors,
   output logic [23:0] xfer_lba,
   output logic [7:0]  xfer_mode,
   output logic [7:0]  tf_status,
   output logic [7:0]  tf_error,
   output logic [7:0]  tf_count,
   output logic        irq_pulse,
   output logic        buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]  buf_data
);

   localparam int M1 = (SENSE_LEN > MODE_LEN) ? SENSE_LEN : MODE_LEN;
   localparam int M2 = (SESS_MAX > STAT_MAX) ? SESS_MAX : STAT_MAX;
   localparam int RESP_MAX = (M1 > M2) ? M1 : M2;

   localparam logic [7:0] CNT_DONE = 8'h03;
   localparam logic [7:0] CNT_IN   = 8'h02;
   localparam logic [7:0] CNT_OUT  = 8'h00;

   logic [11:0][7:0]          pkt;
   logic                      attn_q;
   dec_s                      dec;
   logic [RESP_MAX-1:0][7:0]  img;
   logic [SENSE_LEN-1:0][7:0] sense;
   logic [MODE_LEN-1:0][7:0]  mode;
   logic                      is_data;

   assign pkt     = pkt_data;
   assign is_data = (dec.kind == K_DIN) || (dec.kind == K_DOUT);

   atapi_pkt_decode #(
      .SENSE_LEN(SENSE_LEN), .MODE_LEN(MODE_LEN), .SESS_MAX(SESS_MAX),
      .STAT_MAX(STAT_MAX), .RESP_MAX(RESP_MAX)
   ) u_dec (
      .pkt(pkt), .attn(attn_q), .disc(disc_present),
      .sense(sense), .mode(mode), .dec(dec), .img(img)
   );

   atapi_sense_store #(
      .SENSE_LEN(SENSE_LEN), .MODE_LEN(MODE_LEN), .MODE_INIT(MODE_INIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .upd(pkt_valid), .code(dec.code),
      .arm(pkt_valid && dec.kind == K_DOUT), .arm_off(dec.moff), .arm_len(dec.len),
      .wr_valid(wr_valid), .wr_data(wr_data),
      .sense(sense), .mode(mode)
   );

   atapi_resp_stream #(.RESP_MAX(RESP_MAX), .ADDR_W(ADDR_W)) u_strm (
      .clk(clk), .rst_n(rst_n),
      .load(pkt_valid && dec.kind == K_DIN), .len(dec.len), .img(img),
      .we(buf_we), .addr(buf_addr), .data(buf_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_code     <= RC_OK;
         xfer_len     <= '0;
         xfer_dir     <= 1'b0;
         xfer_dma     <= 1'b0;
         xfer_sectors <= '0;
         xfer_lba     <= '0;
         xfer_mode    <= '0;
         tf_status    <= 8'h00;
         tf_error     <= 8'h01;
         tf_count     <= 8'h01;
         irq_pulse    <= 1'b0;
         attn_q       <= 1'b1;
      end else begin
         res_valid <= pkt_valid;
         irq_pulse <= 1'b0;
         if (pkt_valid) begin
            res_code <= dec.code;
            xfer_len <= is_data ? dec.len : 16'd0;
            xfer_dir <= (dec.kind == K_DIN);
            xfer_dma <= is_data && feat_dma;
            if (attn_q && pkt[0] != OP_RSENSE) attn_q <= 1'b0;
            unique case (dec.kind)
               K_DIN, K_DOUT: begin
                  tf_error  <= 8'h00;
                  tf_count  <= (dec.kind == K_DIN) ? CNT_IN : CNT_OUT;
                  tf_status <= feat_dma ? ST_DMA : ST_PIO;
                  irq_pulse <= !feat_dma;
               end
               K_DONE: begin
                  tf_error  <= 8'h00;
                  tf_count  <= CNT_DONE;
                  tf_status <= ST_RDY;
                  irq_pulse <= 1'b1;
               end
               K_SEEK: begin
                  tf_error     <= 8'h00;
                  tf_count     <= CNT_DONE;
                  tf_status    <= tf_status & ST_KEEP;
                  xfer_lba     <= dec.lba;
                  xfer_sectors <= dec.sectors;
                  xfer_mode    <= dec.smode;
               end
               default: begin
                  tf_error  <= {dec.code[3:0], 4'h0};
                  tf_count  <= CNT_DONE;
                  tf_status <= ST_ERR;
                  irq_pulse <= 1'b1;
               end
            endcase
         end
      end
   end

   // R3: an error result carries the error status and an interrupt
   a_r3_err_flags: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_code != RC_OK |-> tf_status == ST_ERR && irq_pulse
                                         && tf_count == CNT_DONE && xfer_len == 16'd0);

   // R5: attention is consumed by an attention result
   a_r5_attn_once: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(attn_q) |-> res_valid && res_code == RC_ATTN);

   // R11: a DMA setup raises no interrupt
   a_r11_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && xfer_dma |-> !irq_pulse && tf_status == ST_DMA);

   // R8: no setup exceeds the largest response
   a_r8_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> xfer_len <= 16'(RESP_MAX));

endmodule

// File: tb/atapi_pkt_core_test.sv
`timescale 1ns/100ps
module atapi_pkt_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [95:0] pkt_data = '0;
   logic        feat_dma = 1'b0;
   logic        disc_present = 1'b1;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        res_valid, xfer_dir, xfer_dma, irq_pulse, buf_we;
   logic [15:0] res_code, xfer_len;
   logic [23:0] xfer_sectors, xfer_lba;
   logic [7:0]  xfer_mode, tf_status, tf_error, tf_count, buf_addr, buf_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;
   logic [7:0] cap [0:63];
   int n;

   always #2.5 clk = ~clk;

   atapi_pkt_core uut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .feat_dma(feat_dma), .disc_present(disc_present),
      .wr_valid(wr_valid), .wr_data(wr_data),
      .res_valid(res_valid), .res_code(res_code), .xfer_len(xfer_len),
      .xfer_dir(xfer_dir), .xfer_dma(xfer_dma), .xfer_sectors(xfer_sectors),
      .xfer_lba(xfer_lba), .xfer_mode(xfer_mode), .tf_status(tf_status),
      .tf_error(tf_error), .tf_count(tf_count), .irq_pulse(irq_pulse),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data)
   );

   typedef struct packed {
      logic [23:0] tag;
      logic [7:0]  op, b1, b2, b4;
      logic        dma, disc;
      logic [15:0] code, len;
      logic [7:0]  st, er, cn;
      logic        irq;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TAB [NV] = '{
      '{"R5",  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h2906, 16'd0,  8'h51, 8'h60, 8'h03, 1'b1},
      '{"R9",  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0000, 16'd0,  8'h50, 8'h00, 8'h03, 1'b1},
      '{"R9",  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h3A02, 16'd0,  8'h51, 8'h20, 8'h03, 1'b1},
      '{"R9",  8'h7E, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h2005, 16'd0,  8'h51, 8'h50, 8'h03, 1'b1},
      '{"R7",  8'h11, 8'h00, 8'h0A, 8'h04, 1'b0, 1'b1, 16'h2405, 16'd0,  8'h51, 8'h50, 8'h03, 1'b1},
      '{"R4",  8'h30, 8'h08, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0000, 16'd0,  8'h50, 8'h00, 8'h03, 1'b0},
      '{"R7",  8'h11, 8'h00, 8'h03, 8'h14, 1'b0, 1'b1, 16'h0000, 16'd7,  8'h58, 8'h00, 8'h02, 1'b1},
      '{"R11", 8'h11, 8'h00, 8'h00, 8'h04, 1'b1, 1'b1, 16'h0000, 16'd4,  8'hD0, 8'h00, 8'h02, 1'b0},
      '{"R8",  8'h15, 8'h00, 8'h00, 8'h09, 1'b0, 1'b1, 16'h0000, 16'd6,  8'h58, 8'h00, 8'h02, 1'b1},
      '{"R8",  8'h40, 8'h01, 8'h00, 8'h28, 1'b0, 1'b1, 16'h0000, 16'd14, 8'h58, 8'h00, 8'h02, 1'b1},
      '{"R8",  8'h40, 8'h01, 8'h00, 8'h05, 1'b0, 1'b1, 16'h0000, 16'd5,  8'h58, 8'h00, 8'h02, 1'b1},
      '{"R8",  8'h40, 8'h00, 8'h00, 8'h05, 1'b0, 1'b1, 16'h2405, 16'd0,  8'h51, 8'h50, 8'h03, 1'b1},
      '{"R6",  8'h13, 8'h00, 8'h00, 8'hC8, 1'b0, 1'b1, 16'h0000, 16'd10, 8'h58, 8'h00, 8'h02, 1'b1},
      '{"R9",  8'h15, 8'h00, 8'h00, 8'h04, 1'b0, 1'b0, 16'h3A02, 16'd0,  8'h51, 8'h20, 8'h03, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [95:0] mk(logic [7:0] op, logic [7:0] b1, logic [7:0] b2, logic [7:0] b4);
      logic [95:0] p = '0;
      p[7:0] = op; p[15:8] = b1; p[23:16] = b2; p[39:32] = b4;
      return p;
   endfunction

   task automatic send(input logic [95:0] p);
      @(negedge clk);
      pkt_data  = p;
      pkt_valid = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
   endtask

   task automatic grab();
      n = 0;
      while (buf_we && n < 64) begin
         cap[buf_addr[5:0]] = buf_data;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1: reset values
      check("R1", {31'd0, res_valid}, 0);
      check("R1", tf_status, 8'h00);
      check("R1", tf_error, 8'h01);
      check("R1", tf_count, 8'h01);
      check("R1", {31'd0, buf_we}, 0);

      for (int i = 0; i < NV; i++) begin
         feat_dma     = TAB[i].dma;
         disc_present = TAB[i].disc;
         send(mk(TAB[i].op, TAB[i].b1, TAB[i].b2, TAB[i].b4));
         check(string'(TAB[i].tag), {31'd0, res_valid}, 1);
         check(string'(TAB[i].tag), res_code, TAB[i].code);
         check(string'(TAB[i].tag), xfer_len, TAB[i].len);
         check(string'(TAB[i].tag), tf_status, TAB[i].st);
         check(string'(TAB[i].tag), tf_error, TAB[i].er);
         check(string'(TAB[i].tag), tf_count, TAB[i].cn);
         check(string'(TAB[i].tag), {31'd0, irq_pulse}, {31'd0, TAB[i].irq});
         grab();
      end
      feat_dma = 1'b0;
      disc_present = 1'b1;

      // R4: sector read fields, status 0x51 -> 0x50, no interrupt
      pkt_data = '0;
      begin
         logic [95:0] p = '0;
         p[7:0] = 8'h30; p[15:8] = 8'h28; p[23:16] = 8'h12; p[31:24] = 8'h34;
         p[39:32] = 8'h56; p[71:64] = 8'h00; p[79:72] = 8'h01; p[87:80] = 8'h02;
         send(p);
      end
      check("R4", xfer_lba, 24'h123456);
      check("R4", xfer_sectors, 24'h000102);
      check("R4", xfer_mode, 8'h28);
      check("R4", tf_status, 8'h50);
      check("R4", {31'd0, irq_pulse}, 0);

      // R2 R6: sense readback shows the previous error, then the cleared key
      send(mk(8'h7E, 0, 0, 0));
      check("R9", res_code, 16'h2005);
      send(mk(8'h13, 0, 0, 8'h0A));
      check("R12", {31'd0, buf_we}, 1);
      grab();
      check("R12", n, 10);
      check("R2", cap[0], 8'hF0);
      check("R2", cap[2], 8'h05);
      check("R2", cap[8], 8'h20);
      check("R6", cap[1], 8'h00);
      send(mk(8'h13, 0, 0, 8'h0A));
      grab();
      check("R6", cap[2], 8'h00);
      check("R6", cap[8], 8'h00);

      // R7: offset readback of the default area
      send(mk(8'h11, 0, 8'h03, 8'h14));
      grab();
      check("R12", n, 7);
      for (int k = 0; k < 7; k++) check("R7", cap[k], 8'hA3 + 8'(k));

      // R8: position status header
      send(mk(8'h40, 8'h01, 0, 8'h0E));
      grab();
      check("R8", n, 14);
      check("R8", {cap[0], cap[1], cap[2], cap[3]}, 32'h0015000E);

      // R10: mode select window of two bytes, third byte ignored
      send(mk(8'h12, 0, 8'h08, 8'h05));
      check("R7", xfer_len, 16'd2);
      check("R11", tf_count, 8'h00);
      check("R11", {31'd0, xfer_dir}, 0);
      for (int k = 0; k < 3; k++) begin
         wr_valid = 1'b1;
         wr_data  = 8'h55 + 8'(k * 8'h11);
         @(negedge clk);
      end
      wr_valid = 1'b0;
      send(mk(8'h11, 0, 8'h00, 8'h0A));
      grab();
      check("R10", n, 10);
      check("R10", cap[7], 8'hA7);
      check("R10", cap[8], 8'h55);
      check("R10", cap[9], 8'h66);

      // R1 R5: reset restores defaults and attention; sense request is exempt
      do_reset();
      check("R1", tf_error, 8'h01);
      send(mk(8'h13, 0, 0, 8'h0A));
      check("R5", res_code, 16'h0000);
      grab();
      check("R1", cap[2], 8'h00);
      check("R1", cap[0], 8'h00);
      send(mk(8'h11, 0, 0, 8'h0A));
      check("R5", res_code, 16'h2906);
      check("R5", {31'd0, buf_we}, 0);
      send(mk(8'h11, 0, 0, 8'h0A));
      check("R5", res_code, 16'h0000);
      grab();
      check("R1", cap[8], 8'hA8);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule